// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Slave

This block models the device side of a three-wire serial EEPROM holding 1 Kbit. A host selects the device with a chip-select line, clocks commands in on a serial data input on rising clock edges, and receives read data on a serial data output. A static organisation input chooses between 128 words of 8 bits and 64 words of 16 bits. The block parses the start bit, the two-bit opcode and the word address. It serves reads, which continue word after word for as long as chip select stays high. It keeps a write-protect latch that is closed at reset and opened only by an enable command. While that latch is open it accepts single-word writes.

The storage is a register file of 128 bytes. A byte-wide preload port lets a testbench or an initialisation path fill it directly. Programming is instantaneous: there is no self-timed write cycle, no busy indication and no bulk erase.

Top module: `mw_eeprom`

## Requirements
- R1: After reset the write-protect latch is closed, so a WRITE issued before any enable command leaves the array unchanged, and `sdo_en` is low.
- R2: With `cs` high, zeros on `di` in the idle state are ignored. A command is a 1 start bit, a 2-bit opcode, then the word address MSB first: 7 bits when `org`=0 and 6 bits when `org`=1. All of these are sampled on the rising edge of `clk`.
- R3: READ is opcode 10. The rising edge that samples the last address bit drives `sdo` to a dummy 0. Each of the following 8 (`org`=0) or 16 (`org`=1) rising edges drives one bit of the addressed word, MSB first.
- R4: With `org`=1, word address a is formed from byte 2a as the upper 8 bits and byte 2a+1 as the lower 8 bits. With `org`=0, word a is byte a.
- R5: While `cs` stays high after the last bit of a word, the next word at address+1 follows at once with no dummy bit. The address wraps from 127 to 0 (`org`=0) or from 63 to 0 (`org`=1).
- R6: `sdo_en` is high only while a READ is shifting out (dummy bit and data) and `cs` is high. It is low whenever `cs` is low.
- R7: Opcode 00 with the two leading address bits 11 opens the write-protect latch. Opcode 00 with the two leading address bits 00 closes it. The remaining address bits are don't-care. The latch otherwise keeps its value until reset.
- R8: WRITE is opcode 01, then the address, then a data word of 8 or 16 bits MSB first. It updates the array on the edge that samples the last data bit, and only when the latch is open.
- R9: READ returns array contents whatever the state of the write-protect latch.
- R10: A rising clock edge sampled with `cs` low abandons any partial command, without a write, and returns the decoder to waiting for a start bit.
- R11: A pulse on `pl_we` writes `pl_data` into byte `pl_addr` on the next rising edge. A preload takes precedence over a serial write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Serial clock; input sampled and output changed on rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| org | input | 1 | Organisation: 0 = 128x8, 1 = 64x16 (static) |
| cs | input | 1 | Chip select, active high |
| di | input | 1 | Serial command, address and data input |
| sdo | output | 1 | Serial read data |
| sdo_en | output | 1 | Output drive enable; low means high impedance |
| pl_we | input | 1 | Preload byte write strobe |
| pl_addr | input | 7 | Preload byte address |
| pl_data | input | 8 | Preload byte value |

## Verification
The hardest state to reach from the ports is a command cut off part way through its data field while the write-protect latch is open. This is the only situation in which a broken abort path would corrupt the array. The stimulus first opens the latch and confirms that a full write succeeds. It then starts a second write, drops chip select three data bits in, and reads the target word back to confirm it is unchanged. The wrap of sequential reads at the top of each organisation is reached by starting the read at the last word and holding chip select across two words.

// File: rtl/mw_pkg.sv
package mw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_OPC,
    ST_ADR,
    ST_RD,
    ST_WD,
    ST_HOLD
  } mw_st_e;

  localparam logic [1:0] OP_MISC  = 2'b00;
  localparam logic [1:0] OP_WRITE = 2'b01;
  localparam logic [1:0] OP_READ  = 2'b10;
endpackage

// File: rtl/mw_rst_sync.sv
module mw_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic [1:0] pipe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= 2'b00;
    else        pipe_q <= {pipe_q[0], 1'b1};
  end

  assign rst_sn = pipe_q[1];
endmodule

// File: rtl/mw_store.sv
module mw_store #(
  parameter int BYTES = 128,
  parameter int AB    = $clog2(BYTES)
) (
  input  logic          clk,
  input  logic          org,
  input  logic          pl_we,
  input  logic [AB-1:0] pl_addr,
  input  logic [7:0]    pl_data,
  input  logic          wr_req,
  input  logic [AB-1:0] wr_addr,
  input  logic [15:0]   wr_data,
  input  logic [AB-1:0] look_addr,
  output logic [15:0]   look_word
);
  logic [7:0] mem [BYTES];

  logic [AB-1:0] wr_hi_idx, wr_lo_idx, rd_hi_idx, rd_lo_idx;

  assign wr_hi_idx = {wr_addr[AB-2:0], 1'b0};
  assign wr_lo_idx = {wr_addr[AB-2:0], 1'b1};
  assign rd_hi_idx = {look_addr[AB-2:0], 1'b0};
  assign rd_lo_idx = {look_addr[AB-2:0], 1'b1};

  always_ff @(posedge clk) begin
    if (pl_we) begin
      mem[pl_addr] <= pl_data;
    end else if (wr_req) begin
      if (org) begin
        mem[wr_hi_idx] <= wr_data[15:8];
        mem[wr_lo_idx] <= wr_data[7:0];
      end else begin
        mem[wr_addr] <= wr_data[7:0];
      end
    end
  end

  // left-aligned word: MSB of the word is bit 15
  always_comb begin
    if (org) look_word = {mem[rd_hi_idx], mem[rd_lo_idx]};
    else     look_word = {mem[look_addr], 8'h00};
  end
endmodule

// File: rtl/mw_wel.sv
module mw_wel (
  input  logic clk,
  input  logic rst_n,
  input  logic open_p,
  input  logic close_p,
  output logic wel_q
);
  logic wel_d;

  always_comb begin
    wel_d = wel_q;
    if (open_p)       wel_d = 1'b1;
    else if (close_p) wel_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wel_q <= 1'b0;
    else        wel_q <= wel_d;
  end

  AST_WEL_OPENS_ON_CMD:  assert property (@(posedge clk) disable iff (!rst_n) $rose(wel_q) |-> $past(open_p));  // R7
  AST_WEL_CLOSES_ON_CMD: assert property (@(posedge clk) disable iff (!rst_n) $fell(wel_q) |-> $past(close_p)); // R7
endmodule

// File: rtl/mw_ctrl.sv
module mw_ctrl
  import mw_pkg::*;
#(
  parameter int AB = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs,
  input  logic          di,
  input  logic          org,
  input  logic          wel,
  input  logic [15:0]   look_word,
  output logic [AB-1:0] look_addr,
  output logic          wr_req,
  output logic [AB-1:0] wr_addr,
  output logic [15:0]   wr_data,
  output logic          open_p,
  output logic          close_p,
  output logic          sdo,
  output logic          sdo_en
);
  localparam int CW = 5;

  mw_st_e        st, st_d;
  logic [1:0]    opc, opc_d;
  logic [AB-2:0] abuf, abuf_d;
  logic [CW-1:0] cnt, cnt_d;
  logic [15:0]   sh, sh_d;
  logic [AB-1:0] ptr, ptr_d;
  logic          sdo_q, sdo_d;

  logic [AB-1:0] amask, full_a, ptr_inc;
  logic [CW-1:0] alen, wlen;
  logic [1:0]    top2;

  assign amask   = org ? {1'b0, {(AB-1){1'b1}}} : {AB{1'b1}};
  assign alen    = org ? CW'(AB-1) : CW'(AB);
  assign wlen    = org ? CW'(16) : CW'(8);
  assign full_a  = {abuf, di} & amask;
  assign ptr_inc = (ptr + {{(AB-1){1'b0}}, 1'b1}) & amask;
  assign top2    = org ? full_a[AB-2:AB-3] : full_a[AB-1:AB-2];

  always_comb begin
    st_d      = st;
    opc_d     = opc;
    abuf_d    = abuf;
    cnt_d     = cnt;
    sh_d      = sh;
    ptr_d     = ptr;
    sdo_d     = sdo_q;
    wr_req    = 1'b0;
    open_p    = 1'b0;
    close_p   = 1'b0;
    look_addr = ptr_inc;
    if (!cs) begin
      st_d = ST_IDLE;
    end else begin
      case (st)
        ST_IDLE: begin
          if (di) begin
            st_d   = ST_OPC;
            cnt_d  = CW'(1);
            abuf_d = '0;
          end
        end
        ST_OPC: begin
          opc_d = {opc[0], di};
          if (cnt == '0) begin
            st_d  = ST_ADR;
            cnt_d = alen - CW'(1);
          end else begin
            cnt_d = cnt - CW'(1);
          end
        end
        ST_ADR: begin
          abuf_d = {abuf[AB-3:0], di};
          if (cnt == '0) begin
            ptr_d = full_a;
            case (opc)
              OP_READ: begin
                st_d      = ST_RD;
                look_addr = full_a;
                sh_d      = look_word;
                sdo_d     = 1'b0;
                cnt_d     = wlen;
              end
              OP_WRITE: begin
                st_d  = ST_WD;
                sh_d  = '0;
                cnt_d = wlen - CW'(1);
              end
              OP_MISC: begin
                open_p  = (top2 == 2'b11);
                close_p = (top2 == 2'b00);
                st_d    = ST_HOLD;
              end
              default: st_d = ST_HOLD;
            endcase
          end else begin
            cnt_d = cnt - CW'(1);
          end
        end
        ST_RD: begin
          sdo_d = sh[15];
          if (cnt == CW'(1)) begin
            ptr_d = ptr_inc;
            sh_d  = look_word;
            cnt_d = wlen;
          end else begin
            sh_d  = {sh[14:0], 1'b0};
            cnt_d = cnt - CW'(1);
          end
        end
        ST_WD: begin
          sh_d = {sh[14:0], di};
          if (cnt == '0) begin
            wr_req = wel;
            st_d   = ST_HOLD;
          end else begin
            cnt_d = cnt - CW'(1);
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= ST_IDLE;
      opc   <= '0;
      abuf  <= '0;
      cnt   <= '0;
      sh    <= '0;
      ptr   <= '0;
      sdo_q <= 1'b0;
    end else begin
      st    <= st_d;
      opc   <= opc_d;
      abuf  <= abuf_d;
      cnt   <= cnt_d;
      sh    <= sh_d;
      ptr   <= ptr_d;
      sdo_q <= sdo_d;
    end
  end

  assign wr_addr = ptr;
  assign wr_data = {sh[14:0], di};
  assign sdo     = sdo_q;
  assign sdo_en  = cs && (st == ST_RD);

  AST_IDLE_AFTER_CS_LOW: assert property (@(posedge clk) disable iff (!rst_n) !cs |=> (st == ST_IDLE)); // R10
  AST_DUMMY_BIT_ZERO:    assert property (@(posedge clk) disable iff (!rst_n) $rose(st == ST_RD) |-> !sdo_q); // R3
  AST_SEQ_ADDR_WRAP:     assert property (@(posedge clk) disable iff (!rst_n)
                           (cs && st == ST_RD && cnt == CW'(1)) |=> (ptr == (($past(ptr) + 1'b1) & amask))); // R5
endmodule

// File: rtl/mw_eeprom.sv
module mw_eeprom #(
  parameter int BYTES = 128,
  localparam int AB   = $clog2(BYTES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          org,
  input  logic          cs,
  input  logic          di,
  output logic          sdo,
  output logic          sdo_en,
  input  logic          pl_we,
  input  logic [AB-1:0] pl_addr,
  input  logic [7:0]    pl_data
);
  logic          rst_sn;
  logic          wel_q, open_p, close_p, wr_req;
  logic [AB-1:0] look_addr, wr_addr;
  logic [15:0]   look_word, wr_data;

  mw_rst_sync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_sn (rst_sn)
  );

  mw_ctrl #(.AB(AB)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_sn),
    .cs        (cs),
    .di        (di),
    .org       (org),
    .wel       (wel_q),
    .look_word (look_word),
    .look_addr (look_addr),
    .wr_req    (wr_req),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .open_p    (open_p),
    .close_p   (close_p),
    .sdo       (sdo),
    .sdo_en    (sdo_en)
  );

  mw_wel u_wel (
    .clk     (clk),
    .rst_n   (rst_sn),
    .open_p  (open_p),
    .close_p (close_p),
    .wel_q   (wel_q)
  );

  mw_store #(.BYTES(BYTES), .AB(AB)) u_store (
    .clk       (clk),
    .org       (org),
    .pl_we     (pl_we),
    .pl_addr   (pl_addr),
    .pl_data   (pl_data),
    .wr_req    (wr_req),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .look_addr (look_addr),
    .look_word (look_word)
  );

  AST_WRITE_NEEDS_LATCH: assert property (@(posedge clk) disable iff (!rst_sn) wr_req |-> wel_q); // R8
  AST_EN_NEEDS_CS:       assert property (@(posedge clk) disable iff (!rst_sn) sdo_en |-> cs);    // R6
endmodule

// File: tb/mw_eeprom_test.sv
module mw_eeprom_test;
  logic       clk = 1'b0;
  logic       rst_n, org, cs, di, pl_we;
  logic [6:0] pl_addr;
  logic [7:0] pl_data;
  logic       sdo, sdo_en;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  logic [7:0] shadow [128];

  always #10 clk = ~clk;

  mw_eeprom uut (
    .clk(clk), .rst_n(rst_n), .org(org), .cs(cs), .di(di),
    .sdo(sdo), .sdo_en(sdo_en),
    .pl_we(pl_we), .pl_addr(pl_addr), .pl_data(pl_data)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] ref_word(logic o, int a);
    if (o) return {shadow[(2*a) % 128], shadow[(2*a+1) % 128]};
    return {8'h00, shadow[a % 128]};
  endfunction

  task automatic preload(int a, logic [7:0] d);
    @(negedge clk);
    pl_we = 1'b1; pl_addr = 7'(a); pl_data = d;
    @(negedge clk);
    pl_we = 1'b0;
    shadow[a] = d;
  endtask

  task automatic cs_off();
    @(negedge clk);
    cs = 1'b0; di = 1'b0;
    @(posedge clk); #1;
  endtask

  task automatic send_bit(logic b);
    @(negedge clk);
    cs = 1'b1; di = b;
    @(posedge clk); #1;
  endtask

  task automatic send_cmd(logic [1:0] op, int a);
    int alen = org ? 6 : 7;
    send_bit(1'b1);
    send_bit(op[1]);
    send_bit(op[0]);
    for (int i = alen - 1; i >= 0; i--) send_bit(a[i]);
  endtask

  task automatic do_read(string tag, int a, int n);
    int w = org ? 16 : 8;
    int m = org ? 64 : 128;
    send_cmd(2'b10, a);
    check({tag, " R3 dummy"}, {31'd0, sdo}, 32'd0);
    check({tag, " R6 en"}, {31'd0, sdo_en}, 32'd1);
    for (int k = 0; k < n; k++) begin
      logic [15:0] got = '0;
      for (int b = 0; b < w; b++) begin
        send_bit(1'b0);
        got = {got[14:0], sdo};
      end
      check(tag, {16'd0, got}, {16'd0, ref_word(org, (a + k) % m)});
    end
    cs_off();
    check({tag, " R6 off"}, {31'd0, sdo_en}, 32'd0);
  endtask

  task automatic do_write(int a, logic [15:0] d);
    int w = org ? 16 : 8;
    send_cmd(2'b01, a);
    for (int b = w - 1; b >= 0; b--) send_bit(d[b]);
    cs_off();
  endtask

  task automatic do_ewen();
    send_cmd(2'b00, org ? 6'b110101 : 7'b1101010);
    cs_off();
  endtask

  task automatic do_ewds();
    send_cmd(2'b00, org ? 6'b001011 : 7'b0010110);
    cs_off();
  endtask

  task automatic apply_reset();
    @(negedge clk);
    rst_n = 1'b0; cs = 1'b0; di = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    apply_reset();
    check("R1 sdo_en after reset", {31'd0, sdo_en}, 32'd0);
    org = 1'b0;
    do_write(10, 16'h005A);
    do_read("R1 write locked after reset", 10, 1);
  endtask

  task automatic t_read8();
    org = 1'b0;
    do_read("R3 read x8 addr5", 5, 2);
    send_bit(1'b0); send_bit(1'b0); send_bit(1'b0);
    do_read("R2 leading zeros", 9, 1);
  endtask

  task automatic t_wrap();
    org = 1'b0;
    do_read("R5 wrap x8", 127, 2);
    org = 1'b1;
    do_read("R4 read x16 addr3", 3, 1);
    do_read("R5 wrap x16", 63, 2);
  endtask

  task automatic t_latch();
    org = 1'b0;
    do_ewen();
    do_write(10, 16'h00A5);
    shadow[10] = 8'hA5;
    do_read("R7 R8 write after enable", 10, 1);
    do_ewds();
    do_write(10, 16'h003C);
    do_read("R7 R9 write after disable", 10, 1);
    org = 1'b1;
    do_ewen();
    do_write(7, 16'hBEEF);
    shadow[14] = 8'hBE; shadow[15] = 8'hEF;
    do_read("R8 R4 write x16", 7, 1);
  endtask

  task automatic t_abort();
    org = 1'b0;
    do_ewen();
    send_cmd(2'b01, 20);
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
    cs_off();
    do_read("R10 aborted write", 20, 1);
    do_ewds();
  endtask

  task automatic t_reset_latch();
    org = 1'b0;
    do_ewen();
    apply_reset();
    do_write(30, 16'h0011);
    do_read("R1 latch cleared by reset", 30, 1);
  endtask

  task automatic t_preload();
    org = 1'b0;
    preload(44, 8'hC3);
    do_read("R11 preload", 44, 1);
  endtask

  initial begin
    rst_n = 1'b0; org = 1'b0; cs = 1'b0; di = 1'b0;
    pl_we = 1'b0; pl_addr = '0; pl_data = '0;
    for (int i = 0; i < 128; i++) preload(i, 8'((i * 37 + 5) & 8'hFF));
    t_reset();
    t_read8();
    t_wrap();
    t_latch();
    t_abort();
    t_reset_latch();
    t_preload();
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule